// File: doc/BRIEF.md
# Serial Receive Line Glitch Filter

This block cleans the raw receive-data line of an asynchronous serial receiver before framing logic sees it. The line is first brought into the local clock domain by a short flop chain. A hold counter then lets the cleaned output take a new level only once the synchronized line has kept that level for a chosen number of clock cycles. Shorter pulses are swallowed, and the output keeps its previous level.

A 2-bit mode input picks the filter strength: one bypass setting and three hold windows of 31, 63 and 127 clock cycles. Any pulse at or above the window passes. This covers the pulse widths of 96, 192 and 384 cycles that each mode must always accept. Changing the mode throws away any partial count, so a transition can never complete on a count gathered under a different window. The output idles high, which is the serial line's rest level.

Top module: `rxd_deglitch`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rxd_clean` is 1 and the hold count is 0.
- R2: `rxd_raw` passes through a two-flop synchronizer. In mode `mode_sel`=2'b00 (bypass), `rxd_clean` copies the line three clocks after it was sampled, so even a one-cycle pulse appears with its full width.
- R3: In mode 2'b01, a new level is taken only after the synchronized line has held it for 31 consecutive cycles. A 30-cycle pulse is fully suppressed, and a 31-cycle pulse appears 33 clocks after its first cycle with a width of 31.
- R4: In mode 2'b10, the hold window is 63 cycles. A 62-cycle pulse is suppressed, and a 63-cycle pulse appears 65 clocks after it starts.
- R5: In mode 2'b11, the hold window is 127 cycles. A 126-cycle pulse is suppressed, and a 127-cycle pulse appears 129 clocks after it starts.
- R6: Pulses of 96 cycles (mode 2'b01), 192 cycles (mode 2'b10) and 384 cycles (mode 2'b11) always pass, and keep their width.
- R7: Any change of `mode_sel` clears the hold count. A pending transition then needs the full window of the new mode, counted from the cycle after the change.
- R8: When the synchronized line returns to the output level, the count clears. Two short pulses split by a gap therefore never add up to a transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd_raw | input | 1 | Unsynchronized serial receive line |
| mode_sel | input | 2 | 00 bypass, 01 / 10 / 11 hold windows of 31 / 63 / 127 cycles |
| rxd_clean | output | 1 | Filtered receive line, idles high |

## Verification
In a filtering mode, a level change on `rxd_raw` that is driven before clock edge k shows on `rxd_clean` after edge k+W+1, where W is the window. In bypass it shows after edge k+2. The release of a pulse follows the same rule, so an accepted pulse keeps its width. The directed cases drive the line half a cycle before an edge and count negative edges from that point. Each case expects the first low output at iteration W+2 (3 in bypass) and expects exactly the pulse width in low samples. A cycle-accurate behavioural model in the bench is also compared with the output on every falling edge. This catches any off-by-one cycle in the delay, including the restart after a mode change. That restart makes the first low output land at iteration 84 instead of the count carried over from the old mode.

// File: rtl/rxdg_pkg.sv
package rxdg_pkg;

   typedef enum logic [1:0] {
      FLT_OFF   = 2'b00,
      FLT_SHORT = 2'b01,
      FLT_MID   = 2'b10,
      FLT_LONG  = 2'b11
   } flt_mode_e;

   localparam logic LINE_IDLE = 1'b1;

endpackage

// File: rtl/rxdg_sync.sv
module rxdg_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic d_sync
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("rxdg_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/rxdg_hold.sv
module rxdg_hold #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             bypass,
   input  logic             restart,
   input  logic [CNT_W-1:0] window,
   output logic             level,
   output logic [CNT_W-1:0] count
);

   import rxdg_pkg::*;

   logic [CNT_W-1:0] last_step;
   logic             differs;

   assign last_step = window - CNT_W'(1);
   assign differs   = (din != level);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= LINE_IDLE;
         count <= '0;
      end else if (bypass) begin
         level <= din;
         count <= '0;
      end else if (restart || !differs) begin
         count <= '0;
      end else if (count == last_step) begin
         level <= din;
         count <= '0;
      end else begin
         count <= count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/rxd_deglitch.sv
module rxd_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int WIN_SHORT   = 31,
   parameter int WIN_MID     = 63,
   parameter int WIN_LONG    = 127
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd_raw,
   input  logic [1:0] mode_sel,
   output logic       rxd_clean
);

   import rxdg_pkg::*;

   localparam int CNT_W = $clog2(WIN_LONG + 1);

   generate
      if (WIN_SHORT < 2 || WIN_MID <= WIN_SHORT || WIN_LONG <= WIN_MID) begin : g_bad_win
         $error("rxd_deglitch: windows must rise strictly and start at 2 or more");
      end
   endgenerate

   logic             rxd_sync;
   logic [1:0]       mode_q;
   logic             restart;
   logic             bypass;
   logic [CNT_W-1:0] window;
   logic [CNT_W-1:0] hold_cnt;

   rxdg_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(LINE_IDLE)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(rxd_raw),
      .d_sync (rxd_sync)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= FLT_OFF;
      else        mode_q <= mode_sel;
   end

   assign restart = (mode_sel != mode_q);
   assign bypass  = (flt_mode_e'(mode_sel) == FLT_OFF);

   always_comb begin
      case (flt_mode_e'(mode_sel))
         FLT_SHORT: window = CNT_W'(WIN_SHORT);
         FLT_MID:   window = CNT_W'(WIN_MID);
         FLT_LONG:  window = CNT_W'(WIN_LONG);
         default:   window = CNT_W'(1);
      endcase
   end

   rxdg_hold #(
      .CNT_W(CNT_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (rxd_sync),
      .bypass (bypass),
      .restart(restart),
      .window (window),
      .level  (rxd_clean),
      .count  (hold_cnt)
   );

endmodule

// File: rtl/rxdg_chk.sv
module rxdg_chk #(
   parameter int CNT_W     = 7,
   parameter int WIN_SHORT = 31,
   parameter int WIN_MID   = 63,
   parameter int WIN_LONG  = 127
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             rxd_sync,
   input logic [CNT_W-1:0] hold_cnt,
   input logic             rxd_clean
);

   function automatic int win_of(input logic [1:0] m);
      case (m)
         2'b01:   return WIN_SHORT;
         2'b10:   return WIN_MID;
         2'b11:   return WIN_LONG;
         default: return 1;
      endcase
   endfunction

   // R1: idle output and empty count right after reset
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rxd_clean == 1'b1 && hold_cnt == '0));

   // R2: bypass copies the synchronized line one clock later
   p_bypass_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_sel) == 2'b00) |-> (rxd_clean == $past(rxd_sync)));

   // R3: a filtered flip happens only at the end of a full window
   p_flip_full_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(rxd_clean) && $past(mode_sel) != 2'b00)
      |-> (int'($past(hold_cnt)) == win_of($past(mode_sel)) - 1));

   // R7: a mode change empties the count
   p_mode_change_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_sel) |=> (hold_cnt == '0));

   // R8: a line back at the output level empties the count
   p_match_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rxd_sync) == $past(rxd_clean)) |-> (hold_cnt == '0));

endmodule

bind rxd_deglitch rxdg_chk #(
   .CNT_W    (CNT_W),
   .WIN_SHORT(WIN_SHORT),
   .WIN_MID  (WIN_MID),
   .WIN_LONG (WIN_LONG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .rxd_sync (rxd_sync),
   .hold_cnt (hold_cnt),
   .rxd_clean(rxd_clean)
);

// File: tb/sim_rxd_deglitch.sv
`timescale 1ns/1ps
module sim_rxd_deglitch;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd_raw = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic       rxd_clean;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   rxd_deglitch u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxd_raw  (rxd_raw),
      .mode_sel (mode_sel),
      .rxd_clean(rxd_clean)
   );

   // behavioural reference: sample queue plus an integer hold count
   logic m_q[$];
   logic m_out;
   int   m_cnt;
   int   m_prev;

   function automatic int win_of(input int m);
      if (m == 1) return 31;
      if (m == 2) return 63;
      if (m == 3) return 127;
      return 1;
   endfunction

   always @(posedge clk) begin
      logic seen;
      if (!rst_n) begin
         m_q = '{1'b1, 1'b1};
         m_out = 1'b1; m_cnt = 0; m_prev = 0;
      end else begin
         seen = m_q[0];
         if (mode_sel == 2'b00) begin
            m_out = seen; m_cnt = 0;
         end else if (int'(mode_sel) != m_prev || seen == m_out) begin
            m_cnt = 0;
         end else begin
            m_cnt++;
            if (m_cnt >= win_of(int'(mode_sel))) begin
               m_out = seen; m_cnt = 0;
            end
         end
         void'(m_q.pop_front());
         m_q.push_back(rxd_raw);
         m_prev = int'(mode_sel);
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) check("model compare R2 R3 R4 R5 R7 R8", int'(rxd_clean), int'(m_out));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog all reqs actual=%0d expected=<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic run_case(input string tag, input logic [1:0] m0,
                           input int a, input int gap, input int b,
                           input int chg_at, input logic [1:0] m1,
                           input int exp_first, input int exp_lows);
      int first = -1;
      int lows = 0;
      int total = a + gap + b + 450;
      mode_sel = m0;
      rxd_raw  = 1'b1;
      repeat (400) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         if (!rxd_clean) begin
            if (first < 0) first = i;
            lows++;
         end
         if (i == chg_at) mode_sel = m1;
         rxd_raw = ((i < a) || (i >= a + gap && i < a + gap + b)) ? 1'b0 : 1'b1;
      end
      check({tag, " first low"}, first, exp_first);
      check({tag, " low count"}, lows, exp_lows);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R1 clean during reset", int'(rxd_clean), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 clean after reset", int'(rxd_clean), 1);

      run_case("R2 bypass 1", 2'b00, 1, 0, 0, -1, 2'b00, 3, 1);
      run_case("R2 bypass 4", 2'b00, 4, 0, 0, -1, 2'b00, 3, 4);
      run_case("R3 reject 30", 2'b01, 30, 0, 0, -1, 2'b01, -1, 0);
      run_case("R3 accept 31", 2'b01, 31, 0, 0, -1, 2'b01, 33, 31);
      run_case("R4 reject 62", 2'b10, 62, 0, 0, -1, 2'b10, -1, 0);
      run_case("R4 accept 63", 2'b10, 63, 0, 0, -1, 2'b10, 65, 63);
      run_case("R5 reject 126", 2'b11, 126, 0, 0, -1, 2'b11, -1, 0);
      run_case("R5 accept 127", 2'b11, 127, 0, 0, -1, 2'b11, 129, 127);
      run_case("R6 pass 96", 2'b01, 96, 0, 0, -1, 2'b01, 33, 96);
      run_case("R6 pass 192", 2'b10, 192, 0, 0, -1, 2'b10, 65, 192);
      run_case("R6 pass 384", 2'b11, 384, 0, 0, -1, 2'b11, 129, 384);
      run_case("R7 mode change", 2'b01, 150, 0, 0, 20, 2'b10, 84, 131);
      run_case("R8 split pulse", 2'b01, 20, 2, 20, -1, 2'b01, -1, 0);
      run_case("R8 split then full", 2'b01, 20, 2, 31, -1, 2'b01, 55, 31);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule